// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects up to 32 interrupt sources into one level interrupt line. Each source owns the same bit position in every register of the block. A hardware event input that is high at a clock edge sets its cause bit, and the bit stays set until software clears it. Each cause bit has its own clearing rule. In write-one-to-clear mode, software writes a 1 to that bit of the cause view or the pending view. In clear-on-read mode, a read of either view clears the bit.

A mask register selects which causes reach the interrupt line. A mask bit of 1 blocks its source. Software can write the mask as a whole word, or it can set and clear single bits through two alias registers, so that no read-modify-write is needed. A pending view returns the causes that are set and not masked. A write-only force register lets a test raise any cause bit from software. The interrupt output is the registered OR of the pending bits.

Registers are word-aligned at byte offsets 0x00 to 0x18, in this order: mode control, cause, pending, force, mask, mask set, mask clear. Reads use a one-cycle registered data port.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, every cause bit and every mode bit is 0, every mask bit is 1, and irq_o is 0.
- R2: When evt_i[n] is high at a clock edge, cause bit n is 1 from the next cycle on, and it stays 1 after evt_i[n] falls until it is cleared.
- R3: When mode bit n is 0 (write-one-to-clear), writing a 1 in bit n to the cause register (0x04) or the pending register (0x08) clears cause bit n. A 0 in bit n of such a write leaves the bit unchanged, and reads never clear it.
- R4: When mode bit n is 1 (clear-on-read), a read of the cause register returns the value before the clear and clears cause bit n. Writes to 0x04 and 0x08 have no effect on that bit.
- R5: A read of the pending register clears only those clear-on-read bits that it returned as 1. Masked clear-on-read bits keep their value.
- R6: The pending register (0x08) reads as cause AND NOT mask.
- R7: Writing the force register (0x0C) sets each cause bit that has a 1 in the write data, and leaves the bits that have a 0. The force register always reads as 0.
- R8: A write to the mask register (0x10) replaces the mask. A 1 written to the mask-set register (0x14) sets that mask bit, and a 1 written to the mask-clear register (0x18) clears it. Both aliases read back the current mask.
- R9: If a hardware event or a force write sets a cause bit in the same cycle that the bit is cleared, the set wins and the bit stays 1.
- R10: irq_o equals the OR of the pending bits as they were one cycle earlier.
- R11: rd_data_o holds, one cycle after rd_en_i, the value of the addressed register, and it is 0 in any cycle that does not follow a read. An address with a nonzero low two bits or a word index of 7 (0x1C) reads as 0, and writes to such an address change nothing.
- R12: The mode register (0x00) can be read and written, and bit n of it selects the clearing rule for cause bit n (0 = write-one-to-clear, 1 = clear-on-read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NUM_SRC | Write data |
| rd_en_i | input | 1 | Read strobe; side effects happen at the same edge |
| rd_data_o | output | NUM_SRC | Read data, registered |
| evt_i | input | NUM_SRC | Hardware event levels, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The per-bit properties expect the bus to be synchronous to clk. They also expect a read and a write never to be issued in the same cycle, because a cycle that does both would combine the two clearing rules on one bit. The stimulus follows these rules: it changes every input at the falling edge, it issues at most one bus operation per cycle, and it also drives random event patterns. It includes accesses to the unmapped word and events that land in the same cycle as a clear. A behavioural model in the bench predicts rd_data_o and irq_o for every cycle, and directed reads check each corner with fixed expected values.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    // Word index of each register, bits [4:2] of the byte address.
    typedef enum logic [2:0] {
        REG_MODE  = 3'd0,
        REG_CAUSE = 3'd1,
        REG_PEND  = 3'd2,
        REG_FORCE = 3'd3,
        REG_MASK  = 3'd4,
        REG_MSET  = 3'd5,
        REG_MCLR  = 3'd6
    } reg_sel_e;

    localparam int unsigned IDX_W = 3;

    typedef struct packed {
        logic mode_we;
        logic cause_w1c;
        logic force_we;
        logic mask_we;
        logic mset_we;
        logic mclr_we;
        logic rd_cause;
        logic rd_pend;
    } bus_strobe_t;

    typedef struct packed {
        logic cause;
        logic mode;
        logic mask;
    } bit_state_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_cause_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output bus_strobe_t       stb_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              hit_o
);
    localparam int unsigned LOW_W = IDX_W + 2;

    logic upper_ok;
    logic [IDX_W-1:0] idx;

    generate
        if (ADDR_W > LOW_W) begin : g_upper
            assign upper_ok = ~|addr_i[ADDR_W-1:LOW_W];
        end else begin : g_noupper
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign idx   = addr_i[LOW_W-1:2];
    assign idx_o = idx;

    always_comb begin
        hit_o = upper_ok && (addr_i[1:0] == 2'b00) && (idx != 3'd7);
        stb_o = '0;
        stb_o.mode_we   = wr_en_i && hit_o && (idx == REG_MODE);
        stb_o.cause_w1c = wr_en_i && hit_o && ((idx == REG_CAUSE) || (idx == REG_PEND));
        stb_o.force_we  = wr_en_i && hit_o && (idx == REG_FORCE);
        stb_o.mask_we   = wr_en_i && hit_o && (idx == REG_MASK);
        stb_o.mset_we   = wr_en_i && hit_o && (idx == REG_MSET);
        stb_o.mclr_we   = wr_en_i && hit_o && (idx == REG_MCLR);
        stb_o.rd_cause  = rd_en_i && hit_o && (idx == REG_CAUSE);
        stb_o.rd_pend   = rd_en_i && hit_o && (idx == REG_PEND);
    end

endmodule

// File: rtl/irq_cause_bit.sv
module irq_cause_bit
    import irq_cause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic force_i,
    input  logic w1c_i,
    input  logic rd_all_i,
    input  logic rd_pend_i,
    input  logic mode_we_i,
    input  logic mode_wd_i,
    input  logic mask_we_i,
    input  logic mask_wd_i,
    input  logic mset_i,
    input  logic mclr_i,
    output logic cause_o,
    output logic mode_o,
    output logic mask_o
);
    bit_state_t s_d, s_q;

    always_comb begin
        logic set_v, pend_v, clr_v;
        s_d    = s_q;
        set_v  = evt_i || force_i;
        pend_v = s_q.cause && !s_q.mask;
        clr_v  = (!s_q.mode && w1c_i)
              || (s_q.mode && rd_all_i)
              || (s_q.mode && rd_pend_i && pend_v);
        s_d.cause = set_v || (s_q.cause && !clr_v);
        if (mode_we_i) s_d.mode = mode_wd_i;
        if (mask_we_i)   s_d.mask = mask_wd_i;
        else if (mset_i) s_d.mask = 1'b1;
        else if (mclr_i) s_d.mask = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cause: 1'b0, mode: 1'b0, mask: 1'b1};
        else        s_q <= s_d;
    end

    assign cause_o = s_q.cause;
    assign mode_o  = s_q.mode;
    assign mask_o  = s_q.mask;

    // R9: a set in the same cycle as any clear leaves the bit at 1
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i || force_i) |=> cause_o);

    // R4: in clear-on-read mode only a read can drop the bit
    p_cor_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode && !rd_all_i && !rd_pend_i) |=> !$fell(cause_o));

    // R3: in write-one-to-clear mode only a write of 1 can drop the bit
    p_w1c_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.mode && !w1c_i) |=> !$fell(cause_o));

    // R5: a pending read leaves a masked bit alone
    p_pend_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend_i && !rd_all_i && s_q.mask) |=> !$fell(cause_o));

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_cause_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               rd_en_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] rdata;
        logic               irq;
    } top_state_t;

    bus_strobe_t        stb;
    logic [IDX_W-1:0]   idx;
    logic               hit;
    logic [NUM_SRC-1:0] cause_q, mode_q, mask_q, pend;
    top_state_t         t_d, t_q;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .stb_o   (stb),
        .idx_o   (idx),
        .hit_o   (hit)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            irq_cause_bit u_bit (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_i     (evt_i[i]),
                .force_i   (stb.force_we  && wr_data_i[i]),
                .w1c_i     (stb.cause_w1c && wr_data_i[i]),
                .rd_all_i  (stb.rd_cause),
                .rd_pend_i (stb.rd_pend),
                .mode_we_i (stb.mode_we),
                .mode_wd_i (wr_data_i[i]),
                .mask_we_i (stb.mask_we),
                .mask_wd_i (wr_data_i[i]),
                .mset_i    (stb.mset_we && wr_data_i[i]),
                .mclr_i    (stb.mclr_we && wr_data_i[i]),
                .cause_o   (cause_q[i]),
                .mode_o    (mode_q[i]),
                .mask_o    (mask_q[i])
            );
        end
    endgenerate

    assign pend = cause_q & ~mask_q;

    always_comb begin
        logic [NUM_SRC-1:0] rv;
        rv = '0;
        if (hit) begin
            case (idx)
                REG_MODE:  rv = mode_q;
                REG_CAUSE: rv = cause_q;
                REG_PEND:  rv = pend;
                REG_MASK, REG_MSET, REG_MCLR: rv = mask_q;
                default:   rv = '0;
            endcase
        end
        t_d.rdata = rd_en_i ? rv : '0;
        t_d.irq   = |pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_data_o = t_q.rdata;
    assign irq_o     = t_q.irq;

    // R10: an unmasked cause raises the line one cycle later
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cause_q & ~mask_q)) |=> irq_o);

    // R10: with nothing pending the line is low one cycle later
    p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(cause_q & ~mask_q)) |=> !irq_o);

    // R11: unmapped or unaligned reads return zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> (rd_data_o == '0));

    // R7: the force register reads as zero
    p_force_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && hit && (idx == REG_FORCE)) |=> (rd_data_o == '0));

endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [N-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [N-1:0]  rd_data;
    logic [N-1:0]  evt = '0;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_cause_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .evt_i(evt), .irq_o(irq)
    );

    // Behavioural reference model
    logic [N-1:0] m_cause, m_mode, m_mask, m_rd;
    logic         m_irq;

    always @(posedge clk or negedge rst_n) begin : model
        logic [N-1:0] pv, clr, setv, rv;
        int  w;
        bit  ok;
        if (!rst_n) begin
            m_cause <= '0; m_mode <= '0; m_mask <= '1; m_irq <= 1'b0; m_rd <= '0;
        end else begin
            w   = int'(addr) / 4;
            ok  = (addr % 4 == 0) && (w != 7);
            pv  = m_cause & ~m_mask;
            clr = '0;
            setv = evt;
            rv  = '0;
            if (ok && rd_en) begin
                if (w == 0) rv = m_mode;
                else if (w == 1) begin rv = m_cause; clr = clr | m_mode; end
                else if (w == 2) begin rv = pv; clr = clr | (m_mode & pv); end
                else if (w >= 4) rv = m_mask;
            end
            if (ok && wr_en) begin
                if (w == 0) m_mode <= wr_data;
                if (w == 1 || w == 2) clr = clr | (wr_data & ~m_mode);
                if (w == 3) setv = setv | wr_data;
                if (w == 4) m_mask <= wr_data;
                if (w == 5) m_mask <= m_mask | wr_data;
                if (w == 6) m_mask <= m_mask & ~wr_data;
            end
            m_cause <= setv | (m_cause & ~clr);
            m_irq   <= |pv;
            m_rd    <= rd_en ? rv : '0;
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R10, R11)
    bit started = 1'b0;
    always @(negedge clk) begin
        if (started && rst_n) begin
            check("R10 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            check("R11 rd_data vs model", rd_data, m_rd);
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [N-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [N-1:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, '0);
        bus_read(5'h10, v); check("R1 mask reset", v, 32'hFFFF_FFFF);
        bus_read(5'h04, v); check("R1 cause reset", v, 32'h0);
        bus_read(5'h00, v); check("R1 mode reset", v, 32'h0);
        // R12 mode register
        bus_write(5'h00, 32'h0000_FF00);
        bus_read(5'h00, v); check("R12 mode readback", v, 32'h0000_FF00);
        // R2 event latch, R3 reads do not clear
        pulse(32'h8);
        bus_read(5'h04, v); check("R2 event latched", v, 32'h8);
        bus_read(5'h04, v); check("R3 read keeps w1c bit", v, 32'h8);
        bus_read(5'h08, v); check("R6 masked pending", v, 32'h0);
        // R8 clear alias, R6 pending view, R10 irq
        bus_write(5'h18, 32'h8);
        bus_read(5'h08, v); check("R6 pending unmasked", v, 32'h8);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        // R3 write-one-to-clear
        bus_write(5'h04, 32'h0);
        bus_read(5'h04, v); check("R3 write 0 no effect", v, 32'h8);
        bus_write(5'h08, 32'h8);
        bus_read(5'h04, v); check("R3 w1c via pending", v, 32'h0);
        check("R10 irq dropped", {31'b0, irq}, 32'h0);
        // R4 clear-on-read through cause
        bus_write(5'h18, 32'h100);
        pulse(32'h300);
        bus_write(5'h04, 32'h300);
        bus_read(5'h04, v); check("R4 write ignored, read value", v, 32'h300);
        bus_read(5'h04, v); check("R4 cleared by read", v, 32'h0);
        // R5 pending read clears only returned bits
        pulse(32'h300);
        bus_read(5'h08, v); check("R5 pending returns unmasked", v, 32'h100);
        bus_read(5'h04, v); check("R5 masked bit kept", v, 32'h200);
        // R7 force register
        bus_write(5'h0C, 32'h0001_0001);
        bus_read(5'h04, v); check("R7 force sets", v, 32'h0001_0001);
        bus_read(5'h0C, v); check("R7 force reads 0", v, 32'h0);
        // R9 set wins over clear
        evt = 32'h1;
        bus_write(5'h04, 32'h1);
        evt = '0;
        bus_read(5'h04, v); check("R9 w1c vs event", v, 32'h0001_0001);
        evt = 32'h100;
        bus_read(5'h04, v); check("R9 read value before set", v, 32'h0001_0001);
        evt = '0;
        bus_read(5'h08, v); check("R9 cor bit survived read", v, 32'h100);
        // R8 mask register and aliases
        bus_write(5'h10, 32'h0F0F_0F0F);
        bus_read(5'h10, v); check("R8 mask write", v, 32'h0F0F_0F0F);
        bus_write(5'h14, 32'hF000_0000);
        bus_read(5'h14, v); check("R8 mask set alias", v, 32'hFF0F_0F0F);
        bus_write(5'h18, 32'h0F00_0000);
        bus_read(5'h18, v); check("R8 mask clear alias", v, 32'hF00F_0F0F);
        // R11 unmapped and unaligned
        bus_read(5'h1C, v); check("R11 unmapped read", v, 32'h0);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_write(5'h11, 32'h0);
        bus_read(5'h10, v); check("R11 mask untouched", v, 32'hF00F_0F0F);
        bus_read(5'h00, v); check("R11 mode untouched", v, 32'h0000_FF00);
        bus_read(5'h04, v); check("R11 cause untouched", v, 32'h0001_0001);
        // Random traffic checked against the model every cycle
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] d;
            int op;
            d  = $urandom;
            op = int'($urandom % 3);
            evt = $urandom & $urandom & $urandom;
            if (op == 0) bus_write(5'(($urandom % 8) * 4), d);
            else if (op == 1) bus_read(5'(($urandom % 8) * 4), d);
            else @(negedge clk);
        end
        evt = '0;
        repeat (3) @(negedge clk);
        disable watchdog;
        finish_run();
    end
endmodule